// File: doc/BRIEF.md
# Power Sign-Change Interrupt Detector

This block watches a stream of signed active-power samples and reports when the sign of the power flips in one chosen direction. A mode input selects the direction: falling (non-negative to negative) or rising (negative to non-negative). When a matching flip is seen, a sticky status flag is set. An interrupt enable routes that flag onto a level interrupt line. Software acknowledges the event by writing one to a clear strobe.

Samples arrive on a valid/ready stream. The block never applies back-pressure: `smp_ready` is held high once reset is released, so every cycle with `smp_valid` high is a transfer. A producer may hold `smp_valid` low for any number of cycles. Those idle cycles leave the stored sign untouched. Mode, enable and clear are plain control pins that are sampled every cycle.

Top module: `power_sign_irq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `stat_flag` and `irq` are 0.
- R2: `smp_ready` is 1 in every cycle outside reset, so each cycle with `smp_valid` high transfers one sample.
- R3: With `dir_mode` = 0, a transferred negative sample that directly follows a transferred non-negative sample sets `stat_flag` on the next clock edge.
- R4: With `dir_mode` = 1, a transferred non-negative sample that directly follows a transferred negative sample sets `stat_flag` on the next clock edge.
- R5: The sign of a sample is its most significant bit: 1 means negative, and 0 (which includes zero) means non-negative. The stored sign changes only on a transfer, and cycles with `smp_valid` low are ignored.
- R6: The first sample transferred after reset only loads the stored sign. It never sets the flag.
- R7: `stat_flag` stays set until a cycle with `flag_clr` = 1. After that edge it reads 0, unless R8 applies.
- R8: If a qualifying transition and `flag_clr` fall in the same cycle, `stat_flag` is 1 afterwards.
- R9: `irq` equals `stat_flag` AND `irq_en` within the same cycle, so the interrupt is held for as long as the flag remains uncleared.
- R10: Changing `dir_mode` does not by itself set the flag. Only a transfer can set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_data | input | SMP_W | Signed power sample, two's complement |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Sample ready, high outside reset |
| dir_mode | input | 1 | 0 reports a falling sign change, 1 reports a rising one |
| irq_en | input | 1 | Interrupt enable for the flag |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| stat_flag | output | 1 | Sticky sign-change status |
| irq | output | 1 | Level interrupt request |

## Verification
A sample or clear applied before a clock edge changes `stat_flag` exactly one edge later. `irq` follows the flag and `irq_en` within the same cycle, with no register in between. The bench drives each cycle's inputs just after a falling edge. It then waits through one rising edge and updates its own model of the stored sign and the flag. At the next falling edge it compares both outputs against that model, so every comparison falls in the cycle the result is due.

// File: rtl/psd_pkg.sv
package psd_pkg;
  typedef enum logic {
    DIR_FALL = 1'b0,
    DIR_RISE = 1'b1
  } psd_dir_e;
endpackage

// File: rtl/psd_sign_tracker.sv
module psd_sign_tracker #(
  parameter int SMP_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [SMP_W-1:0] sample,
  output logic             ev_fall,
  output logic             ev_rise
);
  logic cur_neg;
  logic prev_neg;
  logic primed;

  assign cur_neg = $signed(sample) < 0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_neg <= 1'b0;
      primed   <= 1'b0;
    end else if (take) begin
      prev_neg <= cur_neg;
      primed   <= 1'b1;
    end
  end

  assign ev_fall = take & primed & ~prev_neg & cur_neg;
  assign ev_rise = take & primed & prev_neg & ~cur_neg;
endmodule

// File: rtl/psd_dir_select.sv
module psd_dir_select
  import psd_pkg::*;
(
  input  psd_dir_e dir,
  input  logic     ev_fall,
  input  logic     ev_rise,
  output logic     hit
);
  always_comb begin
    unique case (dir)
      DIR_FALL: hit = ev_fall;
      DIR_RISE: hit = ev_rise;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/psd_sticky_flag.sv
module psd_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= set | (flag & ~clr);
  end
endmodule

// File: rtl/power_sign_irq.sv
module power_sign_irq
  import psd_pkg::*;
#(
  parameter int SMP_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic             dir_mode,
  input  logic             irq_en,
  input  logic             flag_clr,
  output logic             stat_flag,
  output logic             irq
);
  logic take;
  logic ev_fall;
  logic ev_rise;
  logic hit;

  assign smp_ready = rst_n;
  assign take      = smp_valid & smp_ready;

  psd_sign_tracker #(.SMP_W(SMP_W)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .sample  (smp_data),
    .ev_fall (ev_fall),
    .ev_rise (ev_rise)
  );

  psd_dir_select u_sel (
    .dir     (psd_dir_e'(dir_mode)),
    .ev_fall (ev_fall),
    .ev_rise (ev_rise),
    .hit     (hit)
  );

  psd_sticky_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (hit),
    .clr   (flag_clr),
    .flag  (stat_flag)
  );

  assign irq = stat_flag & irq_en;
endmodule

// File: rtl/power_sign_irq_chk.sv
module power_sign_irq_chk (
  input logic clk,
  input logic rst_n,
  input logic smp_valid,
  input logic smp_ready,
  input logic irq_en,
  input logic flag_clr,
  input logic stat_flag,
  input logic irq
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else if (smp_valid && smp_ready) seen <= 1'b1;
  end

  a_r2_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready);

  a_r6_no_flag_before_first: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> !stat_flag);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_flag && !flag_clr) |=> stat_flag);

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !smp_valid) |=> !stat_flag);

  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && stat_flag) |-> irq);

  a_r10_set_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !$rose(stat_flag));
endmodule

bind power_sign_irq power_sign_irq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_valid (smp_valid),
  .smp_ready (smp_ready),
  .irq_en    (irq_en),
  .flag_clr  (flag_clr),
  .stat_flag (stat_flag),
  .irq       (irq)
);

// File: tb/sim_power_sign_irq.sv
module sim_power_sign_irq;
  localparam int CLK_P = 10;
  localparam int W     = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] smp_data = '0;
  logic         smp_valid = 1'b0;
  logic         smp_ready;
  logic         dir_mode = 1'b0;
  logic         irq_en = 1'b0;
  logic         flag_clr = 1'b0;
  logic         stat_flag;
  logic         irq;

  int checks = 0;
  int fails  = 0;

  logic m_prev_neg = 1'b0;
  logic m_primed   = 1'b0;
  logic m_flag     = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  power_sign_irq #(.SMP_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .dir_mode(dir_mode), .irq_en(irq_en),
    .flag_clr(flag_clr), .stat_flag(stat_flag), .irq(irq)
  );

  function automatic logic model_hit(logic primed, logic prev_neg, logic cur_neg, logic mode);
    if (!primed) return 1'b0;
    return mode ? (prev_neg && !cur_neg) : (!prev_neg && cur_neg);
  endfunction

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step(logic v, logic [W-1:0] d, logic mode, logic en, logic clr, string req);
    logic hit;
    smp_valid = v; smp_data = d; dir_mode = mode; irq_en = en; flag_clr = clr;
    hit = v && model_hit(m_primed, m_prev_neg, d[W-1], mode);
    @(posedge clk);
    m_flag = hit || (m_flag && !clr);
    if (v) begin m_prev_neg = d[W-1]; m_primed = 1'b1; end
    @(negedge clk);
    check(req, stat_flag, m_flag, "stat_flag");
    check("R9", irq, m_flag && en, "irq");
    check("R2", smp_ready, 1'b1, "smp_ready");
  endtask

  localparam logic [W-1:0] POS  = 24'h000123;
  localparam logic [W-1:0] NEG  = 24'hFFF000;
  localparam logic [W-1:0] ZERO = 24'h000000;

  initial begin
    #(CLK_P*200000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R1", stat_flag, 1'b0, "flag in reset");
    check("R1", irq, 1'b0, "irq in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", stat_flag, 1'b0, "flag after reset");

    // R6: the first sample is negative and must not set the flag
    step(1, NEG, 0, 1, 0, "R6");
    step(1, POS, 0, 1, 0, "R3");   // rising transition in falling mode: no event
    step(1, NEG, 0, 1, 0, "R3");   // falling: set
    step(0, POS, 0, 1, 0, "R7");   // held
    step(1, NEG, 0, 0, 0, "R9");   // masked irq, flag held
    step(0, POS, 0, 1, 1, "R7");   // cleared
    // R5: invalid samples are ignored
    step(0, POS, 0, 1, 0, "R5");
    step(1, NEG, 0, 1, 0, "R5");   // stored sign still negative, no event
    step(1, ZERO, 1, 1, 0, "R5");  // zero counts as non-negative: rise in mode 1
    step(0, ZERO, 1, 1, 1, "R7");
    // R10: mode switching alone does nothing
    step(0, NEG, 0, 1, 0, "R10");
    step(0, NEG, 1, 1, 0, "R10");
    step(1, ZERO, 0, 1, 0, "R10"); // stored non-negative stays, no event
    // R8: set together with clear
    step(1, NEG, 0, 1, 1, "R8");
    step(1, POS, 1, 1, 1, "R8");
    step(0, POS, 1, 1, 1, "R7");

    for (int i = 0; i < 4000; i++) begin
      logic v, m, e, c;
      logic [W-1:0] d;
      v = ($urandom % 10) < 7;
      m = (i / 300) % 2 == 1;
      e = ($urandom % 4) != 0;
      c = ($urandom % 10) == 0;
      d = W'($urandom);
      step(v, d, m, e, c, m ? "R4" : "R3");
    end

    // R6 again after a second reset
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", stat_flag, 1'b0, "flag in second reset");
    rst_n = 1'b1;
    m_primed = 1'b0; m_prev_neg = 1'b0; m_flag = 1'b0;
    step(1, NEG, 0, 1, 0, "R6");
    step(1, POS, 1, 1, 0, "R4");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule